// File: doc/BRIEF.md
# Smart Card Parity Error and Retransmit Controller

This block supervises character-level error handling on an asynchronous half-duplex smart card link. It sits between a character UART engine and the register file. Received characters arrive as single-cycle events with a parity-ok qualifier. Transmitted characters report completion together with a flag that says whether the card signalled NAK. A 3-bit allowed-error setting N and a protocol select drive the behaviour. In character protocol (T=0), consecutive bad characters are counted and a good character clears the count. NAKed transmissions are re-requested up to N times. In block protocol (T=1), the first bad character is flagged at once, and NAKs are neither retried nor flagged.

Two sticky flags report errors to software. A status-read strobe clears them, but a new error event in the same cycle keeps them set. When N is zero, automatic retransmission is off. The block then withholds transmit-start permission for 27 half-ETU ticks after the start of each character, which gives the 13.5 ETU spacing. Two FIFO-reset command bits clear themselves one cycle after they are written.

The transmit side is a three-state machine. TX_IDLE moves to TX_WAIT on a character start. TX_WAIT returns to TX_IDLE on a clean completion, on any completion in T=1, or on a NAK with no retries left (the exhaust transition, which raises the error flags). TX_WAIT moves to TX_RESEND on a NAK while retries remain (the retry transition). TX_RESEND holds the retransmit request until the next character start, which returns it to TX_WAIT.

Top module: `scpe_ctrl`

## Requirements
- R1: After reset, retx_req, parity_err, budget_over, tx_fifo_clr and rx_fifo_clr are 0, and tx_allow is 1.
- R2: In T=0 (proto_t1=0), parity_err and budget_over both rise on the clock edge of the (N+1)-th consecutive bad-parity received character (rx_valid=1, rx_parity_ok=0). They do not rise on any earlier one.
- R3: In T=0, a received character with good parity resets the consecutive-error count to zero.
- R4: parity_err and budget_over stay set until a stat_rd cycle clears them. If an error event and stat_rd occur in the same cycle, the flag is set.
- R5: In T=1, the first bad-parity character sets parity_err regardless of N, and budget_over is not set by received characters.
- R6: In T=0, a NAKed completion (tx_done=1, tx_nak=1) with fewer than N retries used raises retx_req from the next cycle until the next tx_start. At most N such requests are made per character.
- R7: In T=0, a NAK arriving after N retries are used (including N=0) raises no retx_req and sets parity_err and budget_over.
- R8: The retry count returns to zero when a character completes without NAK, or when tbuf_wr is pulsed.
- R9: With N=0, tx_allow is 0 from the edge after tx_start until 27 half_etu_tick pulses have been counted, then 1. With N nonzero, tx_allow is 1.
- R10: tx_fifo_clr and rx_fifo_clr are 1 for exactly the one cycle after their write strobe and 0 otherwise.
- R11: In T=1, a NAKed completion raises neither retx_req nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proto_t1 | input | 1 | 1 selects block protocol T=1, 0 selects character protocol T=0 |
| err_limit | input | 3 | Allowed-error setting N |
| rx_valid | input | 1 | Received-character event |
| rx_parity_ok | input | 1 | Parity of the received character was correct |
| tx_start | input | 1 | Start bit of a transmitted character begins |
| tx_done | input | 1 | Transmitted character finished |
| tx_nak | input | 1 | Card NAKed the finished character |
| tbuf_wr | input | 1 | Software loaded the transmit buffer |
| stat_rd | input | 1 | Status register read strobe |
| half_etu_tick | input | 1 | One pulse per half ETU |
| tx_fifo_clr_wr | input | 1 | Software wrote 1 to the transmit FIFO reset bit |
| rx_fifo_clr_wr | input | 1 | Software wrote 1 to the receive FIFO reset bit |
| retx_req | output | 1 | Retransmit the same character |
| parity_err | output | 1 | Sticky parity-error flag |
| budget_over | output | 1 | Sticky error-budget-exceeded flag |
| tx_allow | output | 1 | Next transmit may start |
| tx_fifo_clr | output | 1 | Self-clearing transmit FIFO reset |
| rx_fifo_clr | output | 1 | Self-clearing receive FIFO reset |

## Verification
The assertions assume that err_limit and proto_t1 are static while characters are in flight. They also assume that tx_done arrives only after a tx_start, and that tbuf_wr never coincides with tx_done. The bench changes configuration only between sequences, after the flags have been cleared with a status read. It always pulses tx_start before a completion and issues each strobe for one cycle, away from other events except in the deliberate same-cycle set-versus-read case.

// File: rtl/scpe_pkg.sv
package scpe_pkg;
    localparam int LIMIT_W = 3;
    localparam int GUARD_TICKS = 27;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_WAIT   = 2'd1,
        TX_RESEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/scpe_rx_errcnt.sv
module scpe_rx_errcnt #(
    parameter int LIMIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               proto_t1,
    input  logic [LIMIT_W-1:0] err_limit,
    input  logic               rx_valid,
    input  logic               rx_parity_ok,
    output logic               pe_evt,
    output logic               budget_evt
);
    logic [LIMIT_W-1:0] err_cnt;
    logic               bad_char;

    assign bad_char = rx_valid && !rx_parity_ok;

    always_comb begin
        pe_evt     = 1'b0;
        budget_evt = 1'b0;
        if (bad_char) begin
            if (proto_t1) begin
                pe_evt = 1'b1;
            end else if (err_cnt >= err_limit) begin
                pe_evt     = 1'b1;
                budget_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (proto_t1) begin
            err_cnt <= '0;
        end else if (rx_valid) begin
            if (rx_parity_ok || err_cnt >= err_limit) begin
                err_cnt <= '0;
            end else begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end

    // R3: a good character in T=0 leaves the count at zero
    p_good_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!proto_t1 && rx_valid && rx_parity_ok) |=> (err_cnt == '0));

    // R5: T=1 bad characters flag at once and never touch the budget
    p_t1_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_t1 && bad_char) |-> (pe_evt && !budget_evt));

    // R2: the count never goes past the setting while configuration is steady
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proto_t1 && $stable(err_limit) && $past(rst_n) && $past(err_cnt <= err_limit))
            |-> (err_cnt <= err_limit));
endmodule

// File: rtl/scpe_tx_retry.sv
module scpe_tx_retry
    import scpe_pkg::*;
#(
    parameter int LIMIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               proto_t1,
    input  logic [LIMIT_W-1:0] err_limit,
    input  logic               tx_start,
    input  logic               tx_done,
    input  logic               tx_nak,
    input  logic               tbuf_wr,
    output logic               retx_req,
    output logic               fail_evt
);
    tx_state_e          state_q, state_d;
    logic [LIMIT_W-1:0] tries_q, tries_d;
    logic               nak_t0;
    logic               have_retry;

    assign nak_t0     = tx_done && tx_nak && !proto_t1;
    assign have_retry = (tries_q < err_limit);

    always_comb begin
        state_d = state_q;
        tries_d = tries_q;
        unique case (state_q)
            TX_IDLE: begin
                if (tx_start) state_d = TX_WAIT;
            end
            TX_WAIT: begin
                if (tx_done) begin
                    if (nak_t0 && have_retry) begin
                        state_d = TX_RESEND;
                        tries_d = tries_q + 1'b1;
                    end else begin
                        state_d = TX_IDLE;
                        tries_d = '0;
                    end
                end
            end
            TX_RESEND: begin
                if (tx_start) state_d = TX_WAIT;
            end
            default: begin
                state_d = TX_IDLE;
                tries_d = '0;
            end
        endcase
        if (tbuf_wr) tries_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            tries_q <= '0;
        end else begin
            state_q <= state_d;
            tries_q <= tries_d;
        end
    end

    always_comb begin
        retx_req = (state_q == TX_RESEND);
        fail_evt = (state_q == TX_WAIT) && nak_t0 && !have_retry;
    end

    // R6: a pending retransmit never exceeds the allowed count
    p_retx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |-> (tries_q <= err_limit));

    // R11: no retry is requested from a T=1 completion
    p_t1_no_retry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT && tx_done && proto_t1) |=> !retx_req);

    // R8: a clean completion leaves the retry count at zero
    p_clean_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT && tx_done && !tx_nak) |=> (tries_q == '0));
endmodule

// File: rtl/scpe_guard_timer.sv
module scpe_guard_timer #(
    parameter int LIMIT_W     = 3,
    parameter int GUARD_TICKS = 27
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIMIT_W-1:0] err_limit,
    input  logic               tx_start,
    input  logic               half_etu_tick,
    output logic               tx_allow
);
    localparam int CNT_W = $clog2(GUARD_TICKS + 1);

    logic [CNT_W-1:0] remain_q;
    logic             hold_en;

    assign hold_en = (err_limit == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (tx_start) begin
            remain_q <= CNT_W'(GUARD_TICKS);
        end else if (half_etu_tick && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign tx_allow = !hold_en || (remain_q == '0);

    // R9: a start with retransmission off withholds permission next cycle
    p_guard_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && hold_en && $stable(err_limit)) |=> !tx_allow);

    // R9: permission only returns on a tick
    p_guard_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_allow && !half_etu_tick && hold_en) |=> (!tx_allow || !hold_en));
endmodule

// File: rtl/scpe_selfclr.sv
module scpe_selfclr (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= wr;
    end

    // R10: the bit drops by itself when not rewritten
    p_selfclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !wr) |=> !pulse);
endmodule

// File: rtl/scpe_ctrl.sv
module scpe_ctrl
    import scpe_pkg::*;
#(
    parameter int LIM_W  = scpe_pkg::LIMIT_W,
    parameter int GUARD  = scpe_pkg::GUARD_TICKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proto_t1,
    input  logic [LIM_W-1:0] err_limit,
    input  logic             rx_valid,
    input  logic             rx_parity_ok,
    input  logic             tx_start,
    input  logic             tx_done,
    input  logic             tx_nak,
    input  logic             tbuf_wr,
    input  logic             stat_rd,
    input  logic             half_etu_tick,
    input  logic             tx_fifo_clr_wr,
    input  logic             rx_fifo_clr_wr,
    output logic             retx_req,
    output logic             parity_err,
    output logic             budget_over,
    output logic             tx_allow,
    output logic             tx_fifo_clr,
    output logic             rx_fifo_clr
);
    localparam int N_CLR = 2;

    logic             rx_pe_evt;
    logic             rx_budget_evt;
    logic             tx_fail_evt;
    logic             pe_set;
    logic             budget_set;
    logic [N_CLR-1:0] clr_wr;
    logic [N_CLR-1:0] clr_q;

    scpe_rx_errcnt #(.LIMIT_W(LIM_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .proto_t1     (proto_t1),
        .err_limit    (err_limit),
        .rx_valid     (rx_valid),
        .rx_parity_ok (rx_parity_ok),
        .pe_evt       (rx_pe_evt),
        .budget_evt   (rx_budget_evt)
    );

    scpe_tx_retry #(.LIMIT_W(LIM_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .proto_t1  (proto_t1),
        .err_limit (err_limit),
        .tx_start  (tx_start),
        .tx_done   (tx_done),
        .tx_nak    (tx_nak),
        .tbuf_wr   (tbuf_wr),
        .retx_req  (retx_req),
        .fail_evt  (tx_fail_evt)
    );

    scpe_guard_timer #(.LIMIT_W(LIM_W), .GUARD_TICKS(GUARD)) u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_limit     (err_limit),
        .tx_start      (tx_start),
        .half_etu_tick (half_etu_tick),
        .tx_allow      (tx_allow)
    );

    assign clr_wr = {rx_fifo_clr_wr, tx_fifo_clr_wr};

    for (genvar gi = 0; gi < N_CLR; gi++) begin : g_clr
        scpe_selfclr u_clr (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (clr_wr[gi]),
            .pulse (clr_q[gi])
        );
    end

    assign tx_fifo_clr = clr_q[0];
    assign rx_fifo_clr = clr_q[1];

    assign pe_set     = rx_pe_evt || tx_fail_evt;
    assign budget_set = rx_budget_evt || tx_fail_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_err  <= 1'b0;
            budget_over <= 1'b0;
        end else begin
            if (pe_set)       parity_err <= 1'b1;
            else if (stat_rd) parity_err <= 1'b0;
            if (budget_set)   budget_over <= 1'b1;
            else if (stat_rd) budget_over <= 1'b0;
        end
    end

    // R4: an error event wins over a same-cycle read
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        budget_set |=> (budget_over && parity_err));

    // R4: a read with no event clears both flags
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !pe_set && !budget_set) |=> (!parity_err && !budget_over));

    // R4: without a read the flags stay set
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !stat_rd) |=> parity_err);

    // R7: retry exhaustion and a retransmit request never coexist
    p_exhaust_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fail_evt |=> !retx_req);
endmodule

// File: tb/scpe_ctrl_bench.sv
module scpe_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       proto_t1 = 1'b0;
    logic [2:0] err_limit = 3'd0;
    logic       rx_valid = 1'b0, rx_parity_ok = 1'b0;
    logic       tx_start = 1'b0, tx_done = 1'b0, tx_nak = 1'b0;
    logic       tbuf_wr = 1'b0, stat_rd = 1'b0, half_etu_tick = 1'b0;
    logic       tx_fifo_clr_wr = 1'b0, rx_fifo_clr_wr = 1'b0;
    logic       retx_req, parity_err, budget_over, tx_allow, tx_fifo_clr, rx_fifo_clr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    scpe_ctrl u_scpe_ctrl (
        .clk(clk), .rst_n(rst_n), .proto_t1(proto_t1), .err_limit(err_limit),
        .rx_valid(rx_valid), .rx_parity_ok(rx_parity_ok), .tx_start(tx_start),
        .tx_done(tx_done), .tx_nak(tx_nak), .tbuf_wr(tbuf_wr), .stat_rd(stat_rd),
        .half_etu_tick(half_etu_tick), .tx_fifo_clr_wr(tx_fifo_clr_wr),
        .rx_fifo_clr_wr(rx_fifo_clr_wr), .retx_req(retx_req), .parity_err(parity_err),
        .budget_over(budget_over), .tx_allow(tx_allow), .tx_fifo_clr(tx_fifo_clr),
        .rx_fifo_clr(rx_fifo_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rx_char(input bit ok);
        rx_valid = 1'b1; rx_parity_ok = ok;
        step();
        rx_valid = 1'b0; rx_parity_ok = 1'b0;
    endtask

    task automatic read_status();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic start_char();
        tx_start = 1'b1; step(); tx_start = 1'b0;
    endtask

    task automatic finish_char(input bit nak);
        tx_done = 1'b1; tx_nak = nak; step(); tx_done = 1'b0; tx_nak = 1'b0;
    endtask

    task automatic etu_tick();
        half_etu_tick = 1'b1; step(); half_etu_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 retx", retx_req, 0);
        chk("R1 pe", parity_err, 0);
        chk("R1 budget", budget_over, 0);
        chk("R1 allow", tx_allow, 1);
        chk("R1 clr", {tx_fifo_clr, rx_fifo_clr}, 0);

        // R2: threshold sweep in T=0
        for (int n = 0; n < 8; n++) begin
            err_limit = 3'(n);
            read_status();
            for (int k = 0; k < n; k++) begin
                rx_char(1'b0);
                chk("R2 early", parity_err, 0);
            end
            rx_char(1'b0);
            chk("R2 pe at N+1", parity_err, 1);
            chk("R2 budget at N+1", budget_over, 1);
            step();
            chk("R4 sticky", parity_err, 1);
            read_status();
            chk("R4 read clears pe", parity_err, 0);
            chk("R4 read clears budget", budget_over, 0);
        end

        // R3: good character restarts the count
        for (int n = 1; n < 8; n++) begin
            err_limit = 3'(n);
            for (int k = 0; k < n; k++) rx_char(1'b0);
            rx_char(1'b1);
            for (int k = 0; k < n; k++) rx_char(1'b0);
            chk("R3 reset by good", parity_err, 0);
            rx_char(1'b0);
            chk("R3 flag after restart", parity_err, 1);
            read_status();
        end

        // R4: set beats same-cycle read
        err_limit = 3'd0;
        rx_valid = 1'b1; rx_parity_ok = 1'b0; stat_rd = 1'b1;
        step();
        rx_valid = 1'b0; stat_rd = 1'b0;
        chk("R4 set wins pe", parity_err, 1);
        chk("R4 set wins budget", budget_over, 1);
        read_status();

        // R5: T=1 flags on the first error
        proto_t1 = 1'b1; err_limit = 3'd7;
        rx_char(1'b1);
        chk("R5 good no flag", parity_err, 0);
        rx_char(1'b0);
        chk("R5 first error", parity_err, 1);
        chk("R5 no budget", budget_over, 0);
        read_status();

        // R11: T=1 NAK ignored
        start_char();
        finish_char(1'b1);
        chk("R11 no retx", retx_req, 0);
        chk("R11 no flag", parity_err, 0);
        proto_t1 = 1'b0;

        // R6 R7: retry sweep
        for (int n = 0; n < 8; n++) begin
            err_limit = 3'(n);
            read_status();
            start_char();
            for (int k = 0; k <= n; k++) begin
                finish_char(1'b1);
                if (k < n) begin
                    chk("R6 retx raised", retx_req, 1);
                    chk("R6 no flag yet", parity_err, 0);
                    step();
                    chk("R6 retx held", retx_req, 1);
                    start_char();
                    chk("R6 retx dropped", retx_req, 0);
                end else begin
                    chk("R7 no retx", retx_req, 0);
                    chk("R7 pe", parity_err, 1);
                    chk("R7 budget", budget_over, 1);
                end
            end
            read_status();
        end

        // R8: clean completion clears retries
        err_limit = 3'd2;
        start_char();
        finish_char(1'b1);
        start_char();
        finish_char(1'b0);
        chk("R8 clean idle", retx_req, 0);
        start_char();
        finish_char(1'b1); chk("R8 retry1 after clean", retx_req, 1);
        start_char();
        finish_char(1'b1); chk("R8 retry2 after clean", retx_req, 1);
        start_char();
        finish_char(1'b1); chk("R8 exhaust", parity_err, 1);
        read_status();

        // R8: buffer write clears retries
        start_char();
        finish_char(1'b1);
        tbuf_wr = 1'b1; step(); tbuf_wr = 1'b0;
        start_char();
        finish_char(1'b1); chk("R8 retry after load", retx_req, 1);
        start_char();
        finish_char(1'b1); chk("R8 second retry after load", retx_req, 1);
        start_char();
        finish_char(1'b1); chk("R8 exhaust after load", parity_err, 1);
        read_status();

        // R9: 27-tick spacing with retransmission off
        err_limit = 3'd0;
        start_char();
        chk("R9 held after start", tx_allow, 0);
        for (int k = 0; k < 26; k++) begin
            etu_tick();
            step();
        end
        chk("R9 held at 26", tx_allow, 0);
        etu_tick();
        chk("R9 free at 27", tx_allow, 1);
        err_limit = 3'd3;
        start_char();
        chk("R9 no hold with retries", tx_allow, 1);
        finish_char(1'b0);

        // R10: self-clearing FIFO resets
        tx_fifo_clr_wr = 1'b1; step(); tx_fifo_clr_wr = 1'b0;
        chk("R10 tx pulse", tx_fifo_clr, 1);
        chk("R10 rx quiet", rx_fifo_clr, 0);
        step();
        chk("R10 tx cleared", tx_fifo_clr, 0);
        rx_fifo_clr_wr = 1'b1; step(); rx_fifo_clr_wr = 1'b0;
        chk("R10 rx pulse", rx_fifo_clr, 1);
        step();
        chk("R10 rx cleared", rx_fifo_clr, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule